// File: doc/BRIEF.md
# Memory-Mapped Byte UART Register Block

This block is a small bus-slave peripheral that sits between a processor bus and a byte-level serial engine. The bus sees four 32-bit word registers: receive data, transmit data, status and control. The serial side is reduced to byte streams. Incoming bytes arrive on a valid/byte pair and wait in an eight-entry circular receive queue. A write to the transmit register sends its low byte out on a valid/byte pair.

The block builds the status word and holds the control word. It keeps a sticky interrupt-pending flag and drives one level interrupt. Software drains received bytes by reading the receive register, and that read removes the oldest byte. The receive queue is flushed by writing the control register with the RX-reset bit set. Bit timing, baud generation and line error detection belong to the serial engine and are not part of this block. The error flags in the status word therefore always read zero.

Bus accesses use separate read and write strobes with a byte address. Only address bits [3:2] are decoded into a word index, so the window is 16 bytes. Read data is registered and appears on the cycle after the read strobe.

Top module: `lite_uart_regif`

## Requirements
- R1: After a synchronous active-high reset:
  - busRdata is 0, irq is 0, txValid is 0 and rxReady is 1.
  - The control register reads 0.
  - The status word reads 0x00000004.
- R2: The word index is busAddr[3:2]: 0 is receive data, 1 is transmit data, 2 is status and 3 is control. A read loads busRdata at the clock edge where busRd is high, and busRdata holds that value until the next read. When busWr and busRd are both high, only the write takes effect.
- R3: Received bytes are returned in arrival order, and up to 8 bytes are held. A receive-data read returns the oldest byte in bits [7:0], with bits [31:8] zero, and removes that byte.
- R4: rxReady is high exactly while fewer than 8 bytes are held. A byte offered while 8 are held is dropped, and the stored bytes do not change.
- R5: A receive-data read while the queue is empty returns 0 and leaves the queue empty.
- R6: Status word bits:
  - bit0 is high when the queue is non-empty.
  - bit1 is high when the queue holds 8 bytes.
  - bit2 is always 1.
  - bit4 is the interrupt-pending flag.
  - bits 3, 5, 6, 7 and 31:8 are 0.
  - The status word reflects the state before the edge at which it is read.
- R7: A control write stores the full 32-bit value, which reads back unchanged. If bit1 of the written value is set, the receive queue is emptied, and a byte offered in the same cycle is dropped.
- R8: The interrupt-pending flag is set in any cycle that ends with the queue non-empty, and on every transmit write. It clears only on reset, or on a control write with bit4 low that leaves the queue empty. Reading status does not change it.
- R9: irq equals the interrupt-pending flag ANDed with control bit4.
- R10: A transmit write raises txValid for exactly the next cycle, with txByte equal to busWdata[7:0]. The transmit register reads back the full written word.
- R11: A write to the status index changes no state, and the status word read after it is unchanged.
- R12: A receive-data read and an arriving byte in the same cycle both take effect. The full test for accepting the byte uses the occupancy before that edge. So on a full queue the read pops and the byte is still dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Byte address; bits [3:2] select the register |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| rxValid | input | 1 | Received byte present |
| rxByte | input | BYTE_W | Received byte |
| rxReady | output | 1 | Receive queue has room |
| txValid | output | 1 | Transmit byte strobe, one cycle |
| txByte | output | BYTE_W | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
A wrong write pointer or occupancy count shows up at the ports in several ways:
- Within a single cycle, rxReady is wrong or the valid and full bits in the status word are wrong.
- On the next receive-data read, a byte comes back out of order, is duplicated, or is lost.

A fault in the interrupt-pending flag shows on irq in the cycle right after the offending access, provided the enable bit is set; otherwise it shows in status bit4 on the next status read. The bench checks every output against a queue-based reference model on every clock. Because of that, each such fault is reported in the first cycle in which it becomes visible.

// File: rtl/liteuart_pkg.sv
package liteuart_pkg;

  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } regIdx_t;

  // status word bit positions
  localparam int ST_RXVALID = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXFULL  = 3;
  localparam int ST_IPEND   = 4;

  // control word bit positions
  localparam int CT_TXRST = 0;
  localparam int CT_RXRST = 1;
  localparam int CT_IE    = 4;

  // strobes from the register control to the receive store
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCmd_t;

endpackage

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import liteuart_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoCmd_t          cmd,
  input  logic [BYTE_W-1:0] inByte,
  output logic [BYTE_W-1:0] headByte,
  output logic [CNT_W-1:0]  occ,
  output logic [CNT_W-1:0]  occNext,
  output logic              notFull
);

  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdSlot;
  logic [BYTE_W-1:0] slots [DEPTH];

  assign notFull = (occ < CNT_W'(DEPTH));
  assign rdSlot  = wrPtr - occ[PTR_W-1:0];
  assign headByte = (occ != '0) ? slots[rdSlot] : '0;

  always_comb begin
    if (cmd.flush) occNext = '0;
    else           occNext = occ + CNT_W'(cmd.push) - CNT_W'(cmd.pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      occ   <= '0;
    end else begin
      occ <= occNext;
      if (cmd.flush)     wrPtr <= '0;
      else if (cmd.push) wrPtr <= wrPtr + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slots[i] <= '0;
      else if (cmd.push && !cmd.flush && (wrPtr == PTR_W'(i)))
        slots[i] <= inByte;
    end
  end

endmodule

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import liteuart_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] headByte,
  input  logic [CNT_W-1:0]  occ,
  input  logic [CNT_W-1:0]  occNext,
  input  logic              notFull,
  output fifoCmd_t          cmd,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              ipend,
  output logic              irq
);

  regIdx_t           idx;
  logic              wrEn, rdEn;
  logic [DATA_W-1:0] ctrlReg, txReg, statusWord, rdMux;
  logic              ipendNext;

  assign idx  = regIdx_t'(busAddr[3:2]);
  assign wrEn = busWr;
  assign rdEn = busRd && !busWr;

  always_comb begin
    cmd.push  = rxValid && notFull;
    cmd.pop   = rdEn && (idx == REG_RXD) && (occ != '0);
    cmd.flush = wrEn && (idx == REG_CTRL) && busWdata[CT_RXRST];
  end

  always_comb begin
    statusWord             = '0;
    statusWord[ST_RXVALID] = (occ != '0);
    statusWord[ST_RXFULL]  = (occ == CNT_W'(DEPTH));
    statusWord[ST_TXEMPTY] = 1'b1;
    statusWord[ST_TXFULL]  = 1'b0;
    statusWord[ST_IPEND]   = ipend;
  end

  always_comb begin
    unique case (idx)
      REG_RXD:  rdMux = DATA_W'(headByte);
      REG_TXD:  rdMux = txReg;
      REG_STAT: rdMux = statusWord;
      REG_CTRL: rdMux = ctrlReg;
      default:  rdMux = '0;
    endcase
  end

  always_comb begin
    ipendNext = ipend;
    if (wrEn && (idx == REG_CTRL) && !busWdata[CT_IE]) ipendNext = 1'b0;
    if (wrEn && (idx == REG_TXD))                      ipendNext = 1'b1;
    if (occNext != '0)                                 ipendNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg  <= '0;
      txReg    <= '0;
      ipend    <= 1'b0;
      busRdata <= '0;
      txValid  <= 1'b0;
      txByte   <= '0;
    end else begin
      ipend   <= ipendNext;
      txValid <= wrEn && (idx == REG_TXD);
      if (rdEn) busRdata <= rdMux;
      if (wrEn && (idx == REG_CTRL)) ctrlReg <= busWdata;
      if (wrEn && (idx == REG_TXD)) begin
        txReg  <= busWdata;
        txByte <= busWdata[BYTE_W-1:0];
      end
    end
  end

  assign irq = ipend && ctrlReg[CT_IE];

endmodule

// File: rtl/lite_uart_regif.sv
module lite_uart_regif
  import liteuart_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              rxReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq
);

  fifoCmd_t          cmd;
  logic [BYTE_W-1:0] headByte;
  logic [CNT_W-1:0]  occ, occNext;
  logic              notFull;
  logic              ipend;

  assign rxReady = notFull;

  uart_rx_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst(rst), .cmd(cmd), .inByte(rxByte),
    .headByte(headByte), .occ(occ), .occNext(occNext), .notFull(notFull)
  );

  uart_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid),
    .headByte(headByte), .occ(occ), .occNext(occNext), .notFull(notFull),
    .cmd(cmd), .txValid(txValid), .txByte(txByte), .ipend(ipend), .irq(irq)
  );

endmodule

// File: rtl/lite_uart_regif_chk.sv
module lite_uart_regif_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busWdata,
  input logic              rxValid,
  input logic              rxReady,
  input logic              txValid,
  input logic [BYTE_W-1:0] txByte,
  input logic              irq,
  input logic [CNT_W-1:0]  occ,
  input logic              ipend
);

  // R4
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!rxReady && rxValid && !busRd && !busWr) |=> $stable(occ));

  // R10
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr[3:2] == 2'd1) |=> (txValid && txByte == $past(busWdata[BYTE_W-1:0])));

  // R10
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(busWr && busAddr[3:2] == 2'd1) |=> !txValid);

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr[3:2] == 2'd3 && busWdata[1]) |=> (occ == '0 && rxReady));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr[3:2] == 2'd3 && !busWdata[4]) |=> !irq);

  // R8
  ipend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (occ != '0) |-> ipend);

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && busRd && !busWr && busAddr[3:2] == 2'd0 && !rxValid) |=> occ == '0);

endmodule

bind lite_uart_regif lite_uart_regif_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .rxValid(rxValid), .rxReady(rxReady), .txValid(txValid),
  .txByte(txByte), .irq(irq), .occ(occ), .ipend(ipend)
);

// File: tb/sim_lite_uart_regif.sv
`timescale 1ns/1ps
module sim_lite_uart_regif;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxReady, txValid, irq;
  logic [7:0]  txByte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  lite_uart_regif u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxByte(rxByte),
    .rxReady(rxReady), .txValid(txValid), .txByte(txByte), .irq(irq)
  );

  // reference model
  byte unsigned q[$];
  logic [31:0]  mCtrl, mTx, mRdata;
  bit           mIpend, mTxV;
  logic [7:0]   mTxB;

  function automatic void modelReset();
    q.delete();
    mCtrl = 0; mTx = 0; mRdata = 0; mIpend = 0; mTxV = 0; mTxB = 0;
  endfunction

  function automatic void modelStep(bit wr, bit rd, logic [3:0] a, logic [31:0] d,
                                    bit rv, logic [7:0] rb);
    int  pre = q.size();
    int  idx = int'(a[3:2]);
    bit  rdE = rd && !wr;
    logic [31:0] st;
    st = 32'h4 | (mIpend ? 32'h10 : 0) | (pre == 8 ? 32'h2 : 0) | (pre != 0 ? 32'h1 : 0);
    if (rdE) begin
      case (idx)
        0: mRdata = (pre != 0) ? 32'(q[0]) : 32'h0;
        1: mRdata = mTx;
        2: mRdata = st;
        default: mRdata = mCtrl;
      endcase
    end
    if (rdE && idx == 0 && pre > 0) void'(q.pop_front());
    if (rv && pre < 8) q.push_back(rb);
    mTxV = 0;
    if (wr && idx == 3) begin
      mCtrl = d;
      if (d[1]) q.delete();
      if (!d[4]) mIpend = 0;
    end
    if (wr && idx == 1) begin
      mTx = d; mTxV = 1; mTxB = d[7:0]; mIpend = 1;
    end
    if (q.size() != 0) mIpend = 1;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "busRdata", busRdata, mRdata);
    chk(tag, "rxReady", rxReady, (q.size() < 8));
    chk(tag, "irq", irq, (mIpend && mCtrl[4]));
    chk(tag, "txValid", txValid, mTxV);
    if (mTxV) chk(tag, "txByte", txByte, mTxB);
  endtask

  task automatic step(bit wr, bit rd, logic [3:0] a, logic [31:0] d,
                      bit rv, logic [7:0] rb, string tag);
    busWr = wr; busRd = rd; busAddr = a; busWdata = d; rxValid = rv; rxByte = rb;
    @(posedge clk);
    modelStep(wr, rd, a, d, rv, rb);
    @(negedge clk);
    busWr = 0; busRd = 0; rxValid = 0;
    compareAll(tag);
  endtask

  task automatic rd(logic [3:0] a, string tag);     step(0, 1, a, 0, 0, 0, tag); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d, string tag); step(1, 0, a, d, 0, 0, tag); endtask
  task automatic push(logic [7:0] b, string tag);   step(0, 0, 0, 0, 1, b, tag); endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compareAll("R1");
    rd(4'h8, "R1");                       // status after reset
    chk("R1", "status", busRdata, 32'h4);
    rd(4'hC, "R1");                       // control after reset

    // R2 register decode and readback
    wr(4'hC, 32'hABCD_0010, "R2");
    rd(4'hC, "R2");
    chk("R7", "ctrl readback", busRdata, 32'hABCD_0010);
    wr(4'h4, 32'h1234_56A5, "R10");
    rd(4'h5, "R10");                      // low address bits ignored
    chk("R10", "tx readback", busRdata, 32'h1234_56A5);
    step(1, 1, 4'h4, 32'h77, 0, 0, "R2"); // write wins over read

    // R8 clear pending with IE low, queue empty
    wr(4'hC, 32'h0, "R8");
    rd(4'h8, "R8");
    chk("R8", "ipend cleared", busRdata[4], 0);

    // R3 ordering
    wr(4'hC, 32'h10, "R9");
    push(8'h11, "R3"); push(8'h22, "R3"); push(8'h33, "R3");
    rd(4'h8, "R6");
    chk("R6", "status 3 held", busRdata, 32'h15);
    rd(4'h0, "R3"); chk("R3", "first", busRdata, 32'h11);
    rd(4'h0, "R3"); chk("R3", "second", busRdata, 32'h22);
    rd(4'h0, "R3"); chk("R3", "third", busRdata, 32'h33);

    // R5 empty read
    rd(4'h0, "R5"); chk("R5", "empty read", busRdata, 0);

    // R8 control write with IE low while non-empty keeps pending
    push(8'h44, "R8");
    wr(4'hC, 32'h0, "R8");
    rd(4'h8, "R8");
    chk("R8", "ipend kept", busRdata[4], 1);
    rd(4'h0, "R8");

    // R4 overflow
    for (int i = 0; i < 10; i++) push(8'(8'hA0 + i), "R4");
    chk("R4", "rxReady full", rxReady, 0);
    rd(4'h8, "R6");
    chk("R6", "status full", busRdata, 32'h17);
    // R11 status write ignored
    wr(4'h8, 32'hFFFF_FFFF, "R11");
    rd(4'h8, "R11");
    chk("R11", "status unchanged", busRdata, 32'h17);
    // R12 pop and push together at full: push dropped
    step(0, 1, 4'h0, 0, 1, 8'hEE, "R12");
    chk("R12", "pop at full", busRdata, 32'hA0);
    chk("R12", "room after", rxReady, 1);
    for (int i = 1; i < 8; i++) begin
      rd(4'h0, "R4");
      chk("R4", "drain order", busRdata, 32'(8'hA0 + i));
    end
    rd(4'h0, "R12"); chk("R12", "dropped byte absent", busRdata, 0);

    // R12 pop and push together mid-queue
    push(8'h01, "R12"); push(8'h02, "R12");
    step(0, 1, 4'h0, 0, 1, 8'h03, "R12");
    rd(4'h0, "R12"); chk("R12", "after pair", busRdata, 32'h02);
    rd(4'h0, "R12"); chk("R12", "after pair 2", busRdata, 32'h03);

    // R7 flush with concurrent byte
    push(8'h55, "R7"); push(8'h66, "R7");
    step(1, 0, 4'hC, 32'h12, 1, 8'h77, "R7");
    rd(4'h8, "R7");
    chk("R7", "flushed status", busRdata, 32'h14);
    rd(4'h0, "R7"); chk("R7", "flushed empty", busRdata, 0);

    // R9 irq gating toggles
    wr(4'hC, 32'h0, "R9");
    push(8'h99, "R9");
    chk("R9", "irq disabled", irq, 0);
    wr(4'hC, 32'h10, "R9");
    chk("R9", "irq enabled", irq, 1);
    rd(4'h0, "R9");

    // mixed traffic against the model
    for (int i = 0; i < 800; i++) begin
      int unsigned r = $urandom;
      bit w = (r[3:0] == 0);
      logic [31:0] d = $urandom;
      if (w && r[9:8] == 2'd3 && r[12:10] != 0) d[1] = 0;
      step(w, r[5:4] != 0, r[11:8], d, r[7:6] != 0, 8'(r >> 16), "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule